// File: doc/BRIEF.md
# Read Prefetch Buffer Controller

This block sits between a local-bus slave and a PCI master engine and manages one read buffer that holds a single 64-byte line, kept as 16 words of 32 bits. Each buffer has a line tag and a valid bit for every word. Small reads arrive on a local request port. A small read is a byte, a halfword, or a 16-byte burst of four words. An input flag comes with each read and says whether the decoded address window is prefetchable.

A read to a non-prefetchable window causes one single-beat PCI read, and its word goes straight back to the requester. A read to a prefetchable window that misses empties the buffer and starts a burst fill from the 64-byte aligned base. The fill may stop early. When it ends, the waiting request is served from the buffer if the words it needs arrived. Otherwise the request is sent back for rearbitration.

Later reads covered by the valid words are answered from the buffer, one word per cycle, with no PCI activity. A read that misses while a fill is running is sent back for rearbitration. A write observed anywhere in the bridge invalidates the buffer. A write seen during a fill makes that fill's data stale, so it is dropped when the fill ends. The guarded page attribute is accepted on the port and has no effect.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: A read with `req_pref`=0 produces exactly one `pci_start` with `pci_burst`=0 and the word-aligned request address. On `pci_beat_valid`, that beat's data is returned as one `resp_valid` word with `resp_last`=1. On `pci_retry`, no data is returned and `req_rearb` pulses once.
- R2: A prefetchable read that misses produces one `pci_start` with `pci_burst`=1 and the address rounded down to 64 bytes. Beats fill words 0,1,2,… of the line in order. After the fill, the waiting request is answered from the buffer.
- R3: A fill ends after 16 beats, or on a beat carrying `pci_disc` or `pci_lat_to`, or on `pci_retry`. Only the words received are valid. If those words cover the waiting request, it is served; otherwise `req_rearb` pulses and no data is returned.
- R4: A read whose tag matches and whose needed words are all valid is served with no `pci_start`. Encodings for `req_size`: 0 = byte, 1 = halfword, 2 = 16-byte burst with addr[3:0]=0. The block returns 1 word, or 4 words for size 2. The first word is line word addr[5:2], rounded down to a multiple of 4 for size 2. Words come on consecutive cycles and `resp_last` marks the final word.
- R5: While a fill runs, a request that misses is accepted (`req_ready`=1). It gets a one-cycle `req_rearb` pulse in the next cycle and causes no `pci_start`.
- R6: When no fill is active, a read that misses (prefetchable or not) empties the buffer before starting its PCI read. A later read to the old line therefore misses.
- R7: `wr_seen` outside a fill invalidates the buffer, so the next read to a previously valid word misses.
- R8: `wr_seen` during a fill marks it stale. All its words are discarded at fill end, and the waiting request gets `req_rearb`.
- R9: `req_guarded` has no effect: guarded prefetchable reads fill and hit exactly like unguarded ones.
- R10: After reset the buffer is empty, `req_ready`=1, and `resp_valid`, `pci_start` and `req_rearb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local read request present |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | 32 | Byte address of the read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 four-word burst |
| req_pref | input | 1 | Decoded window is prefetchable |
| req_guarded | input | 1 | Guarded page attribute (ignored) |
| req_rearb | output | 1 | One-cycle pulse: request must be retried |
| resp_valid | output | 1 | Read data word valid |
| resp_data | output | 32 | Read data word |
| resp_last | output | 1 | Final word of the response |
| pci_start | output | 1 | One-cycle pulse starting a PCI read |
| pci_addr | output | 32 | PCI read start address |
| pci_burst | output | 1 | 1 = line fill burst, 0 = single beat |
| pci_beat_valid | input | 1 | PCI read data beat |
| pci_beat_data | input | 32 | PCI read data |
| pci_disc | input | 1 | Target disconnect, ends the transfer |
| pci_retry | input | 1 | Target retry, ends the transfer without data |
| pci_lat_to | input | 1 | Master latency timer expiry, ends the burst |
| wr_seen | input | 1 | A write to the bridge was observed |

## Verification
The assertions assume that the PCI engine drives beats, disconnects, retries and timeouts only while a PCI read started by this block is outstanding. They also assume that 16-byte burst requests are aligned to 16 bytes and that a requester keeps `req_valid` high until `req_ready`. The bench's engine model reacts only to an observed `pci_start`. It stops driving once the programmed beat count or ending condition has been applied. Every request it issues uses size codes 0 to 2 with aligned burst addresses. Side requests and write strobes are injected only at a chosen beat of an active fill.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SINGLE = 3'd1,
        ST_FILL   = 3'd2,
        ST_POST   = 3'd3,
        ST_SERVE  = 3'd4,
        ST_RET1   = 3'd5
    } pf_state_e;

    localparam logic [1:0] SZ_BYTE   = 2'd0;
    localparam logic [1:0] SZ_HALF   = 2'd1;
    localparam logic [1:0] SZ_LINE16 = 2'd2;

endpackage

// File: rtl/pfb_store.sv
module pfb_store #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [DW-1:0]    set_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [WORDS-1:0] valid_mask
);

    logic [WORDS-1:0] valid_d, valid_q;
    logic [DW-1:0]    mem_q [WORDS];

    always_comb begin
        valid_d = valid_q;
        if (set_en) valid_d[set_idx] = 1'b1;
        if (clr)    valid_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (set_en && (set_idx == IDX_W'(g))) mem_q[g] <= set_data;
        end
    end

    assign rd_data    = mem_q[rd_idx];
    assign valid_mask = valid_q;

endmodule

// File: rtl/pfb_match.sv
module pfb_match
    import pfb_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int WORDS       = 16,
    parameter int BURST_WORDS = 4,
    localparam int BYTE_W = $clog2(DW / 8),
    localparam int IDX_W  = $clog2(WORDS),
    localparam int OFF_W  = IDX_W + BYTE_W,
    localparam int TAG_W  = AW - OFF_W,
    localparam int CNT_W  = $clog2(BURST_WORDS + 1)
) (
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       size,
    input  logic [TAG_W-1:0] tag,
    input  logic             tag_ok,
    input  logic [WORDS-1:0] valid,
    output logic             hit,
    output logic [IDX_W-1:0] first,
    output logic [CNT_W-1:0] nwords
);

    localparam logic [IDX_W-1:0] BMASK = ~IDX_W'(BURST_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   lo, hi;
    logic [WORDS-1:0] need;

    assign idx    = addr[OFF_W-1:BYTE_W];
    assign first  = (size == SZ_LINE16) ? (idx & BMASK) : idx;
    assign nwords = (size == SZ_LINE16) ? CNT_W'(BURST_WORDS) : CNT_W'(1);
    assign lo     = {1'b0, first};
    assign hi     = lo + (IDX_W + 1)'(nwords);

    for (genvar g = 0; g < WORDS; g++) begin : g_need
        assign need[g] = ((IDX_W + 1)'(g) >= lo) && ((IDX_W + 1)'(g) < hi);
    end

    assign hit = tag_ok && (addr[AW-1:OFF_W] == tag) && ((need & ~valid) == '0);

endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
    import pfb_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int WORDS       = 16,
    parameter int BURST_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_pref,
    input  logic          req_guarded,
    output logic          req_rearb,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data,
    output logic          resp_last,
    output logic          pci_start,
    output logic [AW-1:0] pci_addr,
    output logic          pci_burst,
    input  logic          pci_beat_valid,
    input  logic [DW-1:0] pci_beat_data,
    input  logic          pci_disc,
    input  logic          pci_retry,
    input  logic          pci_lat_to,
    input  logic          wr_seen
);

    localparam int BYTE_W = $clog2(DW / 8);
    localparam int IDX_W  = $clog2(WORDS);
    localparam int OFF_W  = IDX_W + BYTE_W;
    localparam int TAG_W  = AW - OFF_W;
    localparam int CNT_W  = $clog2(BURST_WORDS + 1);

    typedef struct packed {
        pf_state_e       st;
        logic [AW-1:0]   paddr;
        logic [1:0]      psize;
        logic [TAG_W-1:0] tag;
        logic            tag_ok;
        logic            stale;
        logic [IDX_W-1:0] fcnt;
        logic [IDX_W-1:0] sidx;
        logic [CNT_W-1:0] srem;
        logic [DW-1:0]   sdata;
        logic            start;
        logic [AW-1:0]   saddr;
        logic            sburst;
        logic            rearb;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             clr, set_en;
    logic [DW-1:0]    rd_data;
    logic [WORDS-1:0] vmask;
    logic [AW-1:0]    m_addr;
    logic [1:0]       m_size;
    logic             m_tag_ok, hit;
    logic [IDX_W-1:0] first;
    logic [CNT_W-1:0] nwords;
    logic             fill_end;
    logic             unused_grd;

    assign unused_grd = req_guarded;

    assign m_addr   = (c_q.st == ST_POST) ? c_q.paddr : req_addr;
    assign m_size   = (c_q.st == ST_POST) ? c_q.psize : req_size;
    assign m_tag_ok = c_q.tag_ok && !((c_q.st == ST_FILL) && c_q.stale);

    pfb_match #(.AW(AW), .DW(DW), .WORDS(WORDS), .BURST_WORDS(BURST_WORDS)) match_i (
        .addr   (m_addr),
        .size   (m_size),
        .tag    (c_q.tag),
        .tag_ok (m_tag_ok),
        .valid  (vmask),
        .hit    (hit),
        .first  (first),
        .nwords (nwords)
    );

    pfb_store #(.DW(DW), .WORDS(WORDS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .set_en     (set_en),
        .set_idx    (c_q.fcnt),
        .set_data   (pci_beat_data),
        .rd_idx     (c_q.sidx),
        .rd_data    (rd_data),
        .valid_mask (vmask)
    );

    assign fill_end = pci_retry || pci_disc || pci_lat_to ||
                      (pci_beat_valid && (c_q.fcnt == IDX_W'(WORDS - 1)));

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        c_d.rearb = 1'b0;
        clr       = 1'b0;
        set_en    = 1'b0;

        if (wr_seen && (c_q.st != ST_FILL)) begin
            clr        = 1'b1;
            c_d.tag_ok = 1'b0;
        end

        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        c_d.st   = ST_SERVE;
                        c_d.sidx = first;
                        c_d.srem = nwords - CNT_W'(1);
                    end else begin
                        clr       = 1'b1;
                        c_d.start = 1'b1;
                        c_d.paddr = req_addr;
                        c_d.psize = req_size;
                        c_d.stale = 1'b0;
                        c_d.fcnt  = '0;
                        if (req_pref) begin
                            c_d.st     = ST_FILL;
                            c_d.saddr  = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
                            c_d.sburst = 1'b1;
                            c_d.tag    = req_addr[AW-1:OFF_W];
                            c_d.tag_ok = 1'b1;
                        end else begin
                            c_d.st     = ST_SINGLE;
                            c_d.saddr  = {req_addr[AW-1:BYTE_W], {BYTE_W{1'b0}}};
                            c_d.sburst = 1'b0;
                            c_d.tag_ok = 1'b0;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (wr_seen) c_d.stale = 1'b1;
                if (req_valid && !hit) c_d.rearb = 1'b1;
                if (pci_beat_valid) begin
                    set_en   = 1'b1;
                    c_d.fcnt = c_q.fcnt + IDX_W'(1);
                end
                if (fill_end) begin
                    c_d.st = ST_POST;
                    if (c_q.stale || wr_seen) begin
                        clr        = 1'b1;
                        c_d.tag_ok = 1'b0;
                    end
                end
            end
            ST_POST: begin
                c_d.stale = 1'b0;
                if (hit) begin
                    c_d.st   = ST_SERVE;
                    c_d.sidx = first;
                    c_d.srem = nwords - CNT_W'(1);
                end else begin
                    c_d.st    = ST_IDLE;
                    c_d.rearb = 1'b1;
                end
            end
            ST_SERVE: begin
                if (c_q.srem == '0) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.sidx = c_q.sidx + IDX_W'(1);
                    c_d.srem = c_q.srem - CNT_W'(1);
                end
            end
            ST_SINGLE: begin
                if (pci_beat_valid) begin
                    c_d.sdata = pci_beat_data;
                    c_d.st    = ST_RET1;
                end else if (pci_retry) begin
                    c_d.st    = ST_IDLE;
                    c_d.rearb = 1'b1;
                end
            end
            ST_RET1: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready  = (c_q.st == ST_IDLE) || ((c_q.st == ST_FILL) && !hit);
    assign req_rearb  = c_q.rearb;
    assign resp_valid = (c_q.st == ST_SERVE) || (c_q.st == ST_RET1);
    assign resp_data  = (c_q.st == ST_RET1) ? c_q.sdata : rd_data;
    assign resp_last  = (c_q.st == ST_RET1) || ((c_q.st == ST_SERVE) && (c_q.srem == '0));
    assign pci_start  = c_q.start;
    assign pci_addr   = c_q.saddr;
    assign pci_burst  = c_q.sburst;

    assert_single_one_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RET1) |=> !resp_valid);
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pci_start |=> !pci_start);
    assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_start && pci_burst) |-> (pci_addr[OFF_W-1:0] == '0));
    assert_serve_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !pci_start);
    assert_rearb_nodata_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_rearb |-> !resp_valid);
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_seen && (c_q.st != ST_FILL)) |=> (vmask == '0));
    assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_FILL) && c_q.stale && fill_end) |=> (vmask == '0));

endmodule

// File: tb/rd_prefetch_ctrl_tb_top.sv
module rd_prefetch_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_pref, req_guarded, req_rearb;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        resp_valid, resp_last;
    logic [31:0] resp_data;
    logic        pci_start, pci_burst;
    logic [31:0] pci_addr;
    logic        pci_beat_valid, pci_disc, pci_retry, pci_lat_to, wr_seen;
    logic [31:0] pci_beat_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rd_prefetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_pref(req_pref), .req_guarded(req_guarded),
        .req_rearb(req_rearb), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_last(resp_last), .pci_start(pci_start), .pci_addr(pci_addr),
        .pci_burst(pci_burst), .pci_beat_valid(pci_beat_valid),
        .pci_beat_data(pci_beat_data), .pci_disc(pci_disc), .pci_retry(pci_retry),
        .pci_lat_to(pci_lat_to), .wr_seen(wr_seen)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        pref;
        logic        grd;
        logic [4:0]  beats;
        logic [1:0]  endk;    // 0 full/normal, 1 disconnect, 2 latency timeout, 3 retry
        logic [1:0]  evt;     // 0 none, 1 write strobe, 2 side request
        logic [4:0]  evt_at;
        logic        exp_pci;
        logic [2:0]  exp_words;
        logic [1:0]  exp_rearb;
        logic [3:0]  rq;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t ROWS [NROWS] = '{
        '{32'h1000_0040, 2'd0, 1'b1, 1'b0, 5'd16, 2'd0, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd2},  // R2 fill
        '{32'h1000_0050, 2'd2, 1'b1, 1'b0, 5'd0,  2'd0, 2'd0, 5'd0, 1'b0, 3'd4, 2'd0, 4'd4},  // R4 burst hit
        '{32'h1000_007C, 2'd1, 1'b1, 1'b0, 5'd0,  2'd0, 2'd0, 5'd0, 1'b0, 3'd1, 2'd0, 4'd4},  // R4 last word
        '{32'h2000_0000, 2'd0, 1'b0, 1'b0, 5'd1,  2'd0, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd1},  // R1 single
        '{32'h1000_0040, 2'd0, 1'b1, 1'b0, 5'd5,  2'd1, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd6},  // R6 emptied
        '{32'h1000_0048, 2'd0, 1'b1, 1'b0, 5'd0,  2'd0, 2'd0, 5'd0, 1'b0, 3'd1, 2'd0, 4'd3},  // R3 partial hit
        '{32'h1000_0058, 2'd0, 1'b1, 1'b0, 5'd8,  2'd2, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd3},  // R3 latency end
        '{32'h1000_0070, 2'd2, 1'b1, 1'b0, 5'd0,  2'd3, 2'd0, 5'd0, 1'b1, 3'd0, 2'd1, 4'd3},  // R3 retry, empty
        '{32'h3000_0000, 2'd0, 1'b0, 1'b0, 5'd0,  2'd3, 2'd0, 5'd0, 1'b1, 3'd0, 2'd1, 4'd1},  // R1 retry
        '{32'h1000_0000, 2'd2, 1'b1, 1'b1, 5'd16, 2'd0, 2'd0, 5'd0, 1'b1, 3'd4, 2'd0, 4'd9},  // R9 guarded fill
        '{32'h1000_003C, 2'd1, 1'b1, 1'b1, 5'd0,  2'd0, 2'd0, 5'd0, 1'b0, 3'd1, 2'd0, 4'd9},  // R9 guarded hit
        '{32'h5000_0000, 2'd0, 1'b1, 1'b0, 5'd16, 2'd0, 2'd2, 5'd3, 1'b1, 3'd1, 2'd1, 4'd5},  // R5 miss in fill
        '{32'h6000_0000, 2'd0, 1'b1, 1'b0, 5'd16, 2'd0, 2'd1, 5'd2, 1'b1, 3'd0, 2'd1, 4'd8},  // R8 stale fill
        '{32'h6000_0000, 2'd0, 1'b1, 1'b0, 5'd16, 2'd0, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd8}   // R8 data dropped
    };

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] dat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input logic [3:0] rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rname(rq), what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_addr = 0; req_size = 0; req_pref = 0; req_guarded = 0;
        pci_beat_valid = 0; pci_beat_data = 0; pci_disc = 0; pci_retry = 0;
        pci_lat_to = 0; wr_seen = 0;
    endtask

    task automatic run_row(input row_t r);
        int npci = 0, nwords = 0, nrearb = 0, ei = 0;
        bit eng = 0, eng_done = 0;
        logic [31:0] saddr = 0;
        logic [3:0]  first;
        logic [31:0] line;
        first = (r.size == 2'd2) ? {r.addr[5:4], 2'b00} : r.addr[5:2];
        line  = {r.addr[31:6], 6'b0};
        @(negedge clk);
        req_valid = 1; req_addr = r.addr; req_size = r.size;
        req_pref = r.pref; req_guarded = r.grd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        for (int cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            idle_inputs();
            if (pci_start) begin
                npci++;
                eng = 1;
                saddr = pci_addr;
                check(pci_burst == r.pref, r.rq, "pci_burst", 32'(pci_burst), 32'(r.pref));
                check(pci_addr == (r.pref ? line : {r.addr[31:2], 2'b00}), r.rq, "pci_addr",
                      pci_addr, r.pref ? line : {r.addr[31:2], 2'b00});
            end
            if (req_rearb) nrearb++;
            if (resp_valid) begin
                logic [31:0] ew;
                ew = line + 32'(({28'd0, first} + 32'(nwords)) * 4);
                check(resp_data == dat(ew), r.rq, "resp_data", resp_data, dat(ew));
                check(resp_last == (nwords == int'(r.exp_words) - 1), r.rq, "resp_last",
                      32'(resp_last), 32'(nwords == int'(r.exp_words) - 1));
                nwords++;
            end
            if (eng && !eng_done) begin
                if (r.evt != 0 && ei == int'(r.evt_at)) begin
                    if (r.evt == 2'd1) wr_seen = 1;
                    else begin
                        req_valid = 1; req_addr = 32'h4000_0000; req_size = 0; req_pref = 1;
                    end
                end
                if (r.endk == 2'd3) begin
                    pci_retry = 1;
                    eng_done = 1;
                end else begin
                    pci_beat_valid = 1;
                    pci_beat_data  = dat(saddr + 32'(ei * 4));
                    if (ei == int'(r.beats) - 1) begin
                        pci_disc   = (r.endk == 2'd1);
                        pci_lat_to = (r.endk == 2'd2);
                        eng_done   = 1;
                    end
                    ei++;
                end
            end
        end
        check(npci == int'(r.exp_pci), r.rq, "pci_start count", 32'(npci), 32'(r.exp_pci));
        check(nwords == int'(r.exp_words), r.rq, "word count", 32'(nwords), 32'(r.exp_words));
        check(nrearb == int'(r.exp_rearb), r.rq, "rearb count", 32'(nrearb), 32'(r.exp_rearb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hang expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state at the ports
        check(req_ready == 1, 4'd10, "req_ready after reset", 32'(req_ready), 1);
        check(resp_valid == 0, 4'd10, "resp_valid after reset", 32'(resp_valid), 0);
        check(pci_start == 0, 4'd10, "pci_start after reset", 32'(pci_start), 0);
        check(req_rearb == 0, 4'd10, "req_rearb after reset", 32'(req_rearb), 0);

        for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

        // R4: buffer holds line 0x6000_0000; hit without PCI activity
        run_row('{32'h6000_0008, 2'd0, 1'b1, 1'b0, 5'd0, 2'd0, 2'd0, 5'd0, 1'b0, 3'd1, 2'd0, 4'd4});
        // R7: write strobe while idle invalidates, same read now misses
        @(negedge clk); wr_seen = 1;
        @(negedge clk); wr_seen = 0;
        run_row('{32'h6000_0008, 2'd0, 1'b1, 1'b0, 5'd16, 2'd0, 2'd0, 5'd0, 1'b1, 3'd1, 2'd0, 4'd7});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule